// File: doc/BRIEF.md
# Eight-bit timer/counter with shared prescaler

This block is an 8-bit up-counter for a small microcontroller. It has two clock sources. In timer mode it advances on instruction-cycle strobes. In counter mode it advances on a chosen edge of an external clock pin, and that pin is synchronized to the core clock first. A single programmable prescaler sits in the counting path. It divides by a power of two from 2 to 256. Software can hand the prescaler to a watchdog path instead. In that case the counter counts 1:1 and the divided strobe goes out on its own port.

Software reads and writes the count over a simple register bus. A write loads the value and clears the prescaler's hidden count. It also holds the counter still for the next two instruction cycles. An increment from FFh to 00h sets a sticky overflow flag. The interrupt output is that flag gated by an enable input. While the sleep input is high, nothing in the counting path moves.

Top module: `tick_timer8`

## Requirements
- R1: After reset, rd_data_o reads 00h and flag_o and irq_o are low.
- R2: With ctrl_i[0]=0 (timer mode), each clock edge with cyc_en_i high is one counting event. With ctrl_i[2]=1 every such event adds one to the count at that edge, and no other edge changes the count.
- R3: With ctrl_i[0]=1 (counter mode), ext_clk_i passes through two synchronizer flops and an edge detector. ctrl_i[1]=0 counts rising edges and ctrl_i[1]=1 counts falling edges; the other edge is ignored. The count changes on the third clock edge after the pin changes.
- R4: With ctrl_i[2]=0, the count advances once per 2^(ctrl_i[5:3]+1) counting events. After a write, the first advance comes on exactly the 2^(ctrl_i[5:3]+1)-th accepted event.
- R5: With ctrl_i[2]=1, the prescaler divides cyc_en_i strobes, and wdt_tick_o is high during every 2^(ctrl_i[5:3]+1)-th strobe. This starts from the last write and continues through hold and sleep. With ctrl_i[2]=0, wdt_tick_o stays low.
- R6: A clock edge with wr_en_i high loads wr_data_i into the count instead of incrementing, and clears the prescaler. rd_data_o always shows the count. A load never sets the flag.
- R7: After a write, the next two edges with cyc_en_i high are blocked. Counting events on or before the second of them are discarded, in both modes.
- R8: An increment from FFh to 00h sets flag_o. flag_o stays set until an edge with flag_clr_i high. When a set and a clear fall on the same edge, the flag ends up set. irq_o is flag_o AND irq_en_i.
- R9: While sleep_i is high the count and the counter-side prescaler do not change, except by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle strobe |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| ctrl_i | input | 6 | [0] counter mode, [1] falling edge, [2] prescaler to watchdog, [5:3] divide select |
| wr_en_i | input | 1 | Write strobe for the count |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Current count |
| flag_clr_i | input | 1 | Clear overflow flag |
| irq_en_i | input | 1 | Interrupt enable |
| sleep_i | input | 1 | Freeze counting |
| flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Gated interrupt |
| wdt_tick_o | output | 1 | Prescaled strobe for the watchdog side |

## Verification
rd_data_o and flag_o are registered. They change on the edge that ends the cycle holding the stimulus, with one exception: a pin transition in counter mode shows up only on the third edge. irq_o and wdt_tick_o are combinational and are due in the same cycle as their inputs. The bench drives inputs just after the falling edge. It checks the combinational outputs a moment later and the registered outputs at the next falling edge, against a cycle model that steps the synchronizer, hold count and prescaler count the same way the requirements describe. Directed runs pin down the exact edge numbers for the hold window, the 1:2 and 1:256 ratios and the pin latency; seeded random traffic covers the rest.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DIV_SEL_W = 3;

  typedef struct packed {
    logic [DIV_SEL_W-1:0] div_sel;
    logic                 pre_to_wdt;
    logic                 fall_edge;
    logic                 ext_mode;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tt_edge_sync.sv
module tt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic evt_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[0] <= 1'b0;
        else         sh_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[g] <= 1'b0;
        else         sh_q[g] <= sh_q[g-1];
      end
    end
  end

  logic rise_w, fall_w;
  assign rise_w = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_w = ~sh_q[STAGES-1] & sh_q[STAGES];
  assign evt_o  = fall_sel_i ? fall_w : rise_w;
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             evt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PRE_W = 1 << SEL_W;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask_w;

  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign mask_w[g] = (SEL_W'(g) <= sel_i);
  end

  assign tick_o = evt_i & ((cnt_q & mask_w) == mask_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (evt_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tt_count_core.sv
module tt_count_core #(
  parameter int CNT_W    = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             cyc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hold_o,
  output logic             flag_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0]    hold_q;
  logic [CNT_W-1:0] count_q;
  logic             flag_q;
  logic             ovf_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hold_q <= '0;
    else if (wr_i)                 hold_q <= HW'(HOLD_CYC);
    else if (cyc_i && hold_q != 0) hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (wr_i)   count_q <= wr_data_i;
    else if (inc_i)  count_q <= count_q + 1'b1;
  end

  assign ovf_w = inc_i & ~wr_i & (&count_q);

  // hardware set beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (ovf_w)      flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign count_o = count_q;
  assign hold_o  = (hold_q != 0);
  assign flag_o  = flag_q;
endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_en_i,
  input  logic              ext_clk_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  rd_data_o,
  input  logic              flag_clr_i,
  input  logic              irq_en_i,
  input  logic              sleep_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wdt_tick_o
);
  tmr_ctrl_t ctrl;
  logic ext_evt, src_evt, run, hold, pre_evt, pre_tick, inc;

  assign ctrl = tmr_ctrl_t'(ctrl_i);

  tt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_clk_i),
    .fall_sel_i (ctrl.fall_edge),
    .evt_o      (ext_evt)
  );

  assign src_evt = ctrl.ext_mode ? ext_evt : cyc_en_i;
  assign run     = ~sleep_i & ~hold;
  // watchdog side keeps the raw cycle strobe; counter side is gated
  assign pre_evt = ctrl.pre_to_wdt ? cyc_en_i : (src_evt & run);

  tt_prescaler #(.SEL_W(DIV_SEL_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_en_i),
    .evt_i  (pre_evt),
    .sel_i  (ctrl.div_sel),
    .tick_o (pre_tick)
  );

  assign inc        = ctrl.pre_to_wdt ? (src_evt & run) : pre_tick;
  assign wdt_tick_o = ctrl.pre_to_wdt & pre_tick;

  tt_count_core #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc),
    .cyc_i      (cyc_en_i),
    .wr_i       (wr_en_i),
    .wr_data_i  (wr_data_i),
    .flag_clr_i (flag_clr_i),
    .count_o    (rd_data_o),
    .hold_o     (hold),
    .flag_o     (flag_o)
  );

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/tick_timer8_chk.sv
module tick_timer8_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_en_i,
  input logic [5:0]       ctrl_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] rd_data_o,
  input logic             flag_clr_i,
  input logic             irq_en_i,
  input logic             sleep_i,
  input logic             flag_o,
  input logic             irq_o,
  input logic             wdt_tick_o
);
  AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i)); // R6
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (rd_data_o == $past(rd_data_o) || rd_data_o == $past(rd_data_o) + 1'b1)); // R2
  AST_TIMER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[0] && ctrl_i[2] && !cyc_en_i && !wr_en_i) |=> $stable(rd_data_o)); // R2
  AST_HOLD_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && !wr_en_i) |=> $stable(rd_data_o)); // R7
  AST_SLEEP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !wr_en_i) |=> $stable(rd_data_o)); // R9
  AST_FLAG_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o == '0 && $past(rd_data_o) == '1 && !$past(wr_en_i)) |-> flag_o); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o); // R8
  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o); // R8
  AST_WDT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[2] |-> !wdt_tick_o); // R5
endmodule

bind tick_timer8 tick_timer8_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cyc_en_i   (cyc_en_i),
  .ctrl_i     (ctrl_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .flag_clr_i (flag_clr_i),
  .irq_en_i   (irq_en_i),
  .sleep_i    (sleep_i),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .wdt_tick_o (wdt_tick_o)
);

// File: tb/tick_timer8_tb.sv
module tick_timer8_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_cyc = 0, d_pin = 0, d_wr = 0, d_clr = 0, d_irqen = 0, d_sleep = 0;
  logic [5:0] d_ctrl = 6'd0;
  logic [7:0] d_wdata = 8'd0;
  logic [7:0] rd_data;
  logic flag, irq, wdt;

  int checks = 0, errors = 0, wdt_seen = 0;
  string tag = "R1";

  logic [7:0] m_cnt = 0, m_pre = 0;
  logic [1:0] m_hold = 0;
  logic       m_flag = 0;
  logic [2:0] m_sh = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer8 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_en_i(d_cyc), .ext_clk_i(d_pin),
    .ctrl_i(d_ctrl), .wr_en_i(d_wr), .wr_data_i(d_wdata), .rd_data_o(rd_data),
    .flag_clr_i(d_clr), .irq_en_i(d_irqen), .sleep_i(d_sleep),
    .flag_o(flag), .irq_o(irq), .wdt_tick_o(wdt)
  );

  task automatic chk(input string t, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", t, got, exp);
    end
  endtask

  function automatic logic [7:0] div_mask(input logic [2:0] sel);
    logic [8:0] m;
    m = (9'd2 << sel) - 9'd1;
    return m[7:0];
  endfunction

  function automatic logic pre_match();
    return (m_pre & div_mask(d_ctrl[5:3])) == div_mask(d_ctrl[5:3]);
  endfunction

  // one clock: comb checks, model step at posedge, registered checks at negedge
  task automatic tick();
    logic ext_evt, src, run, pre_in, inc, exp_wdt;
    #1;
    exp_wdt = d_ctrl[2] && d_cyc && pre_match();
    chk({tag, " wdt_tick"}, int'(wdt), int'(exp_wdt));
    chk({tag, " irq"}, int'(irq), int'(m_flag & d_irqen));
    if (wdt) wdt_seen++;
    @(posedge clk);
    ext_evt = d_ctrl[1] ? (!m_sh[1] && m_sh[2]) : (m_sh[1] && !m_sh[2]);
    src = d_ctrl[0] ? ext_evt : d_cyc;
    run = !d_sleep && (m_hold == 0);
    if (d_ctrl[2]) begin
      pre_in = d_cyc;
      inc = src && run;
    end else begin
      pre_in = src && run;
      inc = pre_in && pre_match();
    end
    if (!d_wr && inc && m_cnt == 8'hff) m_flag = 1'b1;
    else if (d_clr) m_flag = 1'b0;
    if (d_wr) m_cnt = d_wdata;
    else if (inc) m_cnt = m_cnt + 8'd1;
    if (d_wr) m_pre = 0;
    else if (pre_in) m_pre = m_pre + 8'd1;
    if (d_wr) m_hold = 2'd2;
    else if (d_cyc && m_hold != 0) m_hold = m_hold - 2'd1;
    m_sh = {m_sh[1:0], d_pin};
    @(negedge clk);
    chk({tag, " count"}, int'(rd_data), int'(m_cnt));
    chk({tag, " flag"}, int'(flag), int'(m_flag));
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write(input logic [7:0] v);
    d_wr = 1; d_wdata = v; d_cyc = 0;
    tick();
    d_wr = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst_n = 1;
    d_irqen = 1;
    #1;
    tag = "R1";
    chk("R1 reset count", int'(rd_data), 0);
    chk("R1 reset flag", int'(flag), 0);
    chk("R1 reset irq", int'(irq), 0);

    // timer mode 1:1, write and hold
    tag = "R6"; d_ctrl = 6'b000_100;
    write(8'h10);
    chk("R6 load", int'(rd_data), 8'h10);
    tag = "R7"; d_cyc = 1;
    run_n(2);
    chk("R7 held two cycles", int'(rd_data), 8'h10);
    tag = "R2";
    run_n(4);
    chk("R2 counts 1:1", int'(rd_data), 8'h14);
    d_cyc = 0; run_n(3);
    chk("R2 idle without strobe", int'(rd_data), 8'h14);

    // prescaler 1:2 and 1:256
    tag = "R4"; d_ctrl = 6'b000_000;
    write(8'h00); d_cyc = 1;
    run_n(10);
    chk("R4 ratio 1:2", int'(rd_data), 4);
    d_ctrl = 6'b111_000;
    write(8'h00); d_cyc = 1;
    run_n(257);
    chk("R4 1:256 before period", int'(rd_data), 0);
    run_n(1);
    chk("R4 1:256 at period", int'(rd_data), 1);

    // watchdog assignment
    tag = "R5"; d_ctrl = 6'b001_100;
    write(8'h00); d_cyc = 1; wdt_seen = 0;
    run_n(16);
    chk("R5 wdt ticks 1:4", wdt_seen, 4);
    chk("R5 counter 1:1", int'(rd_data), 14);

    // overflow flag
    tag = "R8"; d_ctrl = 6'b000_100;
    write(8'hfe); d_cyc = 1;
    run_n(4);
    chk("R8 wrap count", int'(rd_data), 0);
    chk("R8 flag set", int'(flag), 1);
    chk("R8 irq on", int'(irq), 1);
    d_irqen = 0; #1;
    chk("R8 irq masked", int'(irq), 0);
    d_cyc = 0; d_clr = 1; tick(); d_clr = 0;
    chk("R8 flag cleared", int'(flag), 0);
    write(8'hff); d_cyc = 1; run_n(2);
    d_clr = 1; tick(); d_clr = 0;
    chk("R8 set beats clear", int'(flag), 1);
    d_cyc = 0; d_clr = 1; tick(); d_clr = 0;

    // counter mode edges and latency
    tag = "R3"; d_ctrl = 6'b000_101;
    write(8'h05); d_cyc = 1; run_n(2); d_cyc = 0;
    d_pin = 1; run_n(2);
    chk("R3 rising not yet", int'(rd_data), 5);
    tick();
    chk("R3 rising counted third edge", int'(rd_data), 6);
    d_pin = 0; run_n(4);
    chk("R3 falling ignored", int'(rd_data), 6);
    d_ctrl = 6'b000_111;
    d_pin = 1; run_n(4);
    chk("R3 rising ignored", int'(rd_data), 6);
    d_pin = 0; run_n(2);
    chk("R3 falling not yet", int'(rd_data), 6);
    tick();
    chk("R3 falling counted", int'(rd_data), 7);

    // sleep
    tag = "R9"; d_ctrl = 6'b000_100; d_sleep = 1; d_cyc = 1;
    run_n(10);
    chk("R9 frozen in sleep", int'(rd_data), 7);
    d_sleep = 0;

    // seeded random traffic
    tag = "R2";
    for (int i = 0; i < 6000; i++) begin
      if (($urandom % 300) == 0) d_ctrl = 6'($urandom);
      d_cyc   = ($urandom % 4) == 0;
      if (($urandom % 3) == 0) d_pin = ~d_pin;
      d_wr    = ($urandom % 97) == 0;
      d_wdata = 8'($urandom);
      if (($urandom % 5) == 0) d_wdata = 8'hf0 | 8'($urandom % 16);
      d_clr   = ($urandom % 40) == 0;
      d_irqen = $urandom % 2;
      if (($urandom % 150) == 0) d_sleep = ~d_sleep;
      tick();
    end
    d_wr = 0;
    finish_run();
  end
endmodule